// File: doc/BRIEF.md
# IR run-length pulse sampler

This block turns the single-bit output of an infrared receiver into a stream of byte-wide run-length symbols. The raw line is brought into the module clock domain, optionally inverted, and then sampled on a slow tick derived from the module clock. A programmable glitch filter rejects short level excursions. A run-length encoder then reports each stretch of constant level as one or more bytes that carry the level and the run length.

The encoder stays silent until the line has shown a pulse for a configurable activity threshold. When the line then stays in the space level for a configurable idle time, the encoder closes the packet with a one-cycle packet-end strobe and goes back to waiting for activity. A downstream FIFO and protocol decoder consume the symbol stream. They are not part of this block.

Top module: `ir_runlen_sampler`

## Requirements
- R1: One line sample is taken every 64 module clocks while `cfg_slow_tick` is 0, and every 128 module clocks while it is 1.
- R2: Each symbol is one byte. Bit 7 is the run's level (1 = pulse, 0 = space). Bits 6:0 hold the run length in samples minus one.
- R3: A run longer than 128 samples is reported as consecutive symbols of the same level. Each full 128-sample piece gives low bits 0x7F, and the remainder follows as the last symbol of that run.
- R4: The raw input passes through a two-flop synchronizer. With `cfg_invert` = 1 the level is inverted, so a low line counts as pulse.
- R5: A level change is accepted only after `cfg_glitch_len` consecutive samples of the new level (values 0 and 1 both accept at once). A shorter excursion is absorbed into the surrounding run. Accepted runs keep their exact lengths.
- R6: The activity threshold is T = (`cfg_act_len`+1) samples, multiplied by 128 when `cfg_act_scale` = 1. While waiting, the first T-1 consecutive pulse samples are not reported. The first run starts at the T-th pulse sample. A pulse shorter than T samples produces no symbol.
- R7: After (`cfg_idle_units`+1)*128 consecutive space samples, the trailing space has been reported as (`cfg_idle_units`+1) symbols of value 0x7F. `pkt_end` is high together with the last of these symbols.
- R8: After `pkt_end`, no symbol is produced until a new activity threshold crossing.
- R9: During and right after reset, `sym_valid` and `pkt_end` are 0 and `sym_data` is 0.
- R10: `sym_valid` is high for exactly one clock per symbol. `pkt_end` is never high without `sym_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Raw receiver line, asynchronous |
| cfg_slow_tick | input | 1 | Sample divider select: 0 = /64, 1 = /128 |
| cfg_invert | input | 1 | Invert the line level |
| cfg_glitch_len | input | 6 | Samples a new level must persist before it is accepted |
| cfg_idle_units | input | 8 | Idle time in units of 128 samples, minus one |
| cfg_act_len | input | 8 | Activity threshold in samples, minus one |
| cfg_act_scale | input | 1 | Multiply the activity threshold by 128 |
| sym_valid | output | 1 | Symbol strobe |
| sym_data | output | 8 | Level and run length minus one |
| pkt_end | output | 1 | Packet-end strobe, coincident with the last symbol |

## Verification
The tick-spacing property assumes that `cfg_slow_tick` changes only rarely. The checker ignores the first interval after each change of that input, and the bench switches the divider only while the line rests in space. The symbol-ordering properties assume that the configuration stays fixed within a packet, so the bench changes the glitch, threshold and idle fields only after a packet has closed. Every level the bench drives lasts a whole number of sample periods, so each run spans a known count of ticks whatever the divider phase.

// File: rtl/ir_rl_pkg.sv
package ir_rl_pkg;
    localparam int RUN_W    = 7;
    localparam int SYM_W    = RUN_W + 1;
    localparam int SCALE_SH = 7;

    typedef enum logic {
        ENC_WAIT = 1'b0,
        ENC_RUN  = 1'b1
    } enc_mode_e;
endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
    parameter int DIV_LO = 64,
    parameter int DIV_HI = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic div_sel,
    output logic tick
);
    localparam int CNT_W = $clog2(DIV_HI);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } tick_st_t;

    tick_st_t st_d, st_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        st_d    = st_q;
        lim     = div_sel ? CNT_W'(DIV_HI - 1) : CNT_W'(DIV_LO - 1);
        if (st_q.cnt >= lim) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;
endmodule

// File: rtl/ir_level_filter.sv
module ir_level_filter #(
    parameter int GLT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ir_raw,
    input  logic             invert,
    input  logic             tick,
    input  logic [GLT_W-1:0] glitch_len,
    output logic             level,
    output logic             step
);
    typedef struct packed {
        logic [1:0]       sync;
        logic             lvl;
        logic [GLT_W-1:0] cnt;
        logic             step;
    } flt_st_t;

    flt_st_t st_d, st_q;
    logic           smp;
    logic [GLT_W:0] cnt_inc;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], ir_raw};
        st_d.step = tick;
        smp       = st_q.sync[1] ^ invert;
        cnt_inc   = {1'b0, st_q.cnt} + 1'b1;
        if (tick) begin
            if (smp == st_q.lvl) begin
                st_d.cnt = '0;
            end else if (cnt_inc >= {1'b0, glitch_len}) begin
                st_d.lvl = smp;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = cnt_inc[GLT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.lvl;
    assign step  = st_q.step;
endmodule

// File: rtl/ir_run_encoder.sv
module ir_run_encoder
    import ir_rl_pkg::*;
#(
    parameter int ACT_W  = 8,
    parameter int IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              level,
    input  logic [ACT_W-1:0]  act_len,
    input  logic              act_scale,
    input  logic [IDLE_W-1:0] idle_units,
    output logic              sym_valid,
    output logic [SYM_W-1:0]  sym_data,
    output logic              pkt_end,
    output logic              active
);
    localparam int ACT_CW  = ACT_W + SCALE_SH + 1;
    localparam int IDLE_CW = IDLE_W + SCALE_SH + 1;
    localparam int LEN_W   = RUN_W + 1;
    localparam logic [LEN_W-1:0] RUN_MAX = LEN_W'(1 << RUN_W);

    typedef struct packed {
        enc_mode_e          mode;
        logic [ACT_CW-1:0]  act_cnt;
        logic [IDLE_CW-1:0] idle_cnt;
        logic               run_lvl;
        logic [LEN_W-1:0]   run_len;
        logic               sym_v;
        logic [SYM_W-1:0]   sym;
        logic               pend;
    } enc_st_t;

    enc_st_t st_d, st_q;
    logic [ACT_CW-1:0]  act_base;
    logic [ACT_CW-1:0]  act_tgt;
    logic [IDLE_CW-1:0] idle_tgt;

    always_comb begin
        act_base = ACT_CW'(act_len) + ACT_CW'(1);
        act_tgt  = act_scale ? (act_base << SCALE_SH) : act_base;
        idle_tgt = (IDLE_CW'(idle_units) + IDLE_CW'(1)) << SCALE_SH;
    end

    always_comb begin
        st_d       = st_q;
        st_d.sym_v = 1'b0;
        st_d.pend  = 1'b0;
        if (step) begin
            unique case (st_q.mode)
                ENC_WAIT: begin
                    if (level) begin
                        if (st_q.act_cnt + 1'b1 >= act_tgt) begin
                            st_d.mode     = ENC_RUN;
                            st_d.act_cnt  = '0;
                            st_d.idle_cnt = '0;
                            st_d.run_lvl  = 1'b1;
                            st_d.run_len  = LEN_W'(1);
                        end else begin
                            st_d.act_cnt = st_q.act_cnt + 1'b1;
                        end
                    end else begin
                        st_d.act_cnt = '0;
                    end
                end
                ENC_RUN: begin
                    if (level == st_q.run_lvl) begin
                        if (st_q.run_len == RUN_MAX) begin
                            st_d.sym_v   = 1'b1;
                            st_d.sym     = {st_q.run_lvl, {RUN_W{1'b1}}};
                            st_d.run_len = LEN_W'(1);
                        end else begin
                            st_d.run_len = st_q.run_len + 1'b1;
                        end
                    end else begin
                        st_d.sym_v   = 1'b1;
                        st_d.sym     = {st_q.run_lvl, RUN_W'(st_q.run_len - 1'b1)};
                        st_d.run_lvl = level;
                        st_d.run_len = LEN_W'(1);
                    end
                    if (level) begin
                        st_d.idle_cnt = '0;
                    end else if (st_q.idle_cnt + 1'b1 >= idle_tgt) begin
                        st_d.sym_v    = 1'b1;
                        st_d.sym      = {1'b0, {RUN_W{1'b1}}};
                        st_d.pend     = 1'b1;
                        st_d.mode     = ENC_WAIT;
                        st_d.act_cnt  = '0;
                        st_d.idle_cnt = '0;
                        st_d.run_len  = '0;
                    end else begin
                        st_d.idle_cnt = st_q.idle_cnt + 1'b1;
                    end
                end
                default: st_d.mode = ENC_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sym_valid = st_q.sym_v;
    assign sym_data  = st_q.sym;
    assign pkt_end   = st_q.pend;
    assign active    = (st_q.mode == ENC_RUN);
endmodule

// File: rtl/ir_runlen_sampler.sv
module ir_runlen_sampler
    import ir_rl_pkg::*;
#(
    parameter int DIV_LO = 64,
    parameter int DIV_HI = 128,
    parameter int GLT_W  = 6,
    parameter int ACT_W  = 8,
    parameter int IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ir_in,
    input  logic              cfg_slow_tick,
    input  logic              cfg_invert,
    input  logic [GLT_W-1:0]  cfg_glitch_len,
    input  logic [IDLE_W-1:0] cfg_idle_units,
    input  logic [ACT_W-1:0]  cfg_act_len,
    input  logic              cfg_act_scale,
    output logic              sym_valid,
    output logic [SYM_W-1:0]  sym_data,
    output logic              pkt_end
);
    logic smp_tick;
    logic flt_level;
    logic flt_step;
    logic enc_active;

    ir_tick_gen #(
        .DIV_LO (DIV_LO),
        .DIV_HI (DIV_HI)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (cfg_slow_tick),
        .tick    (smp_tick)
    );

    ir_level_filter #(
        .GLT_W (GLT_W)
    ) u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .ir_raw     (ir_in),
        .invert     (cfg_invert),
        .tick       (smp_tick),
        .glitch_len (cfg_glitch_len),
        .level      (flt_level),
        .step       (flt_step)
    );

    ir_run_encoder #(
        .ACT_W  (ACT_W),
        .IDLE_W (IDLE_W)
    ) u_enc (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (flt_step),
        .level      (flt_level),
        .act_len    (cfg_act_len),
        .act_scale  (cfg_act_scale),
        .idle_units (cfg_idle_units),
        .sym_valid  (sym_valid),
        .sym_data   (sym_data),
        .pkt_end    (pkt_end),
        .active     (enc_active)
    );
endmodule

// File: rtl/ir_runlen_sampler_chk.sv
module ir_runlen_sampler_chk #(
    parameter int DIV_LO = 64,
    parameter int DIV_HI = 128
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       div_sel,
    input logic       sym_valid,
    input logic [7:0] sym_data,
    input logic       pkt_end,
    input logic       active
);
    logic [15:0] gap_q;
    logic        seen_q;
    logic        sel_q;
    logic        have_last_q;
    logic [7:0]  last_sym_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q       <= '0;
            seen_q      <= 1'b0;
            sel_q       <= 1'b0;
            have_last_q <= 1'b0;
            last_sym_q  <= '0;
        end else begin
            sel_q <= div_sel;
            if (div_sel != sel_q) seen_q <= 1'b0;
            else if (tick)        seen_q <= 1'b1;
            if (tick)                gap_q <= 16'd1;
            else if (gap_q != '1)    gap_q <= gap_q + 1'b1;
            if (sym_valid) begin
                have_last_q <= !pkt_end;
                last_sym_q  <= sym_data;
            end
        end
    end

    a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && seen_q && div_sel == sel_q) |-> gap_q == (div_sel ? 16'(DIV_HI) : 16'(DIV_LO)));

    a_r10_end_with_symbol: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |-> sym_valid);

    a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |=> !sym_valid);

    a_r7_end_is_full_space: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |-> sym_data == 8'h7F);

    a_r3_level_change_after_partial: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && have_last_q && last_sym_q[6:0] != 7'h7F) |-> sym_data[7] != last_sym_q[7]);

    a_r6_first_is_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && !have_last_q) |-> sym_data[7]);

    a_r8_quiet_when_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && !pkt_end) |-> active);
endmodule

bind ir_runlen_sampler ir_runlen_sampler_chk #(
    .DIV_LO (DIV_LO),
    .DIV_HI (DIV_HI)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (smp_tick),
    .div_sel   (cfg_slow_tick),
    .sym_valid (sym_valid),
    .sym_data  (sym_data),
    .pkt_end   (pkt_end),
    .active    (enc_active)
);

// File: tb/ir_runlen_sampler_bench.sv
`timescale 1ns/1ps
module ir_runlen_sampler_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ir_in = 1'b0;
    logic       cfg_slow_tick = 1'b0;
    logic       cfg_invert = 1'b0;
    logic [5:0] cfg_glitch_len = 6'd1;
    logic [7:0] cfg_idle_units = 8'd0;
    logic [7:0] cfg_act_len = 8'd3;
    logic       cfg_act_scale = 1'b0;
    logic       sym_valid;
    logic [7:0] sym_data;
    logic       pkt_end;

    int   n_vec = 0;
    int   n_bad = 0;
    int   smp_div = 64;
    int   dbl_valid = 0;
    logic phys_inv = 1'b0;
    logic prev_valid = 1'b0;
    bit   done = 1'b0;
    logic [8:0] got[$];

    always #4 clk = ~clk;

    ir_runlen_sampler u_ir_runlen_sampler (
        .clk            (clk),
        .rst_n          (rst_n),
        .ir_in          (ir_in),
        .cfg_slow_tick  (cfg_slow_tick),
        .cfg_invert     (cfg_invert),
        .cfg_glitch_len (cfg_glitch_len),
        .cfg_idle_units (cfg_idle_units),
        .cfg_act_len    (cfg_act_len),
        .cfg_act_scale  (cfg_act_scale),
        .sym_valid      (sym_valid),
        .sym_data       (sym_data),
        .pkt_end        (pkt_end)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (sym_valid || pkt_end)
                got.push_back({pkt_end, sym_valid ? sym_data : 8'hEE});
            if (sym_valid && prev_valid) dbl_valid++;
            prev_valid = sym_valid;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_vec++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    task automatic drive(input logic lvl, input int n);
        ir_in = lvl ^ phys_inv;
        repeat (n * smp_div) @(negedge clk);
    endtask

    task automatic check_seq(input string req, input logic [8:0] exp_q[$]);
        check(req, "symbol count", got.size(), exp_q.size());
        foreach (exp_q[i]) begin
            if (i < got.size())
                check(req, $sformatf("symbol %0d", i), 32'(got[i]), 32'(exp_q[i]));
        end
        got.delete();
    endtask

    // R9: outputs quiet in and after reset
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R9", "sym_valid in reset", 32'(sym_valid), 32'd0);
        check("R9", "pkt_end in reset", 32'(pkt_end), 32'd0);
        check("R9", "sym_data in reset", 32'(sym_data), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R9", "sym_valid after reset", 32'(sym_valid), 32'd0);
    endtask

    // R2, R7, R8: basic packet, then a sub-threshold pulse after close
    task automatic t_basic();
        logic [8:0] e[$];
        drive(1'b0, 10);
        drive(1'b1, 20);
        drive(1'b0, 10);
        drive(1'b1, 5);
        drive(1'b0, 128 + 16);
        drive(1'b1, 2);
        drive(1'b0, 16);
        e = '{9'h090, 9'h009, 9'h084, 9'h17F};
        check_seq("R2", e);
    endtask

    // R3: long pulse split into saturated pieces
    task automatic t_saturate();
        logic [8:0] e[$];
        drive(1'b0, 4);
        drive(1'b1, 264);
        drive(1'b0, 128 + 16);
        e = '{9'h0FF, 9'h0FF, 9'h084, 9'h17F};
        check_seq("R3", e);
    endtask

    // R5: glitch filter absorbs a short gap, keeps run lengths
    task automatic t_glitch();
        logic [8:0] e[$];
        cfg_glitch_len = 6'd8;
        drive(1'b0, 4);
        drive(1'b1, 34);
        drive(1'b0, 3);
        drive(1'b1, 20);
        drive(1'b0, 12);
        drive(1'b1, 10);
        drive(1'b0, 128 + 20);
        e = '{9'h0B5, 9'h00B, 9'h089, 9'h17F};
        check_seq("R5", e);
        cfg_glitch_len = 6'd1;
    endtask

    // R4: inverted line polarity yields the same symbols
    task automatic t_invert();
        logic [8:0] e[$];
        phys_inv   = 1'b1;
        cfg_invert = 1'b1;
        drive(1'b0, 10);
        drive(1'b1, 20);
        drive(1'b0, 10);
        drive(1'b1, 5);
        drive(1'b0, 128 + 16);
        e = '{9'h090, 9'h009, 9'h084, 9'h17F};
        check_seq("R4", e);
        phys_inv   = 1'b0;
        cfg_invert = 1'b0;
        drive(1'b0, 4);
        check("R4", "no symbol on polarity restore", got.size(), 0);
        got.delete();
    endtask

    // R1: slow divider doubles the sample period
    task automatic t_slow_tick();
        logic [8:0] e[$];
        cfg_slow_tick = 1'b1;
        smp_div       = 128;
        drive(1'b0, 4);
        drive(1'b1, 10);
        drive(1'b0, 3);
        drive(1'b1, 2);
        drive(1'b0, 128 + 16);
        e = '{9'h086, 9'h002, 9'h081, 9'h17F};
        check_seq("R1", e);
        cfg_slow_tick = 1'b0;
        smp_div       = 64;
        drive(1'b0, 4);
        got.delete();
    endtask

    // R6: short pulses ignored; scaled threshold
    task automatic t_threshold();
        logic [8:0] e[$];
        drive(1'b1, 3);
        drive(1'b0, 20);
        check("R6", "pulse below threshold", got.size(), 0);
        got.delete();
        cfg_act_len   = 8'd0;
        cfg_act_scale = 1'b1;
        drive(1'b1, 100);
        drive(1'b0, 20);
        check("R6", "pulse below scaled threshold", got.size(), 0);
        got.delete();
        drive(1'b1, 138);
        drive(1'b0, 128 + 16);
        e = '{9'h08A, 9'h17F};
        check_seq("R6", e);
        cfg_act_len   = 8'd3;
        cfg_act_scale = 1'b0;
    endtask

    // R7: two idle units give two saturated spaces, end on the second
    task automatic t_long_idle();
        logic [8:0] e[$];
        cfg_idle_units = 8'd1;
        drive(1'b0, 4);
        drive(1'b1, 6);
        drive(1'b0, 256 + 16);
        e = '{9'h082, 9'h07F, 9'h17F};
        check_seq("R7", e);
        cfg_idle_units = 8'd0;
    endtask

    initial begin
        t_reset();
        t_basic();
        t_saturate();
        t_glitch();
        t_invert();
        t_slow_tick();
        t_threshold();
        t_long_idle();
        check("R10", "back-to-back strobes", dbl_valid, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule